// File: doc/BRIEF.md
# Floating-Point Sticky Flag and Exception Request Unit

This block sits beside a floating-point datapath and keeps the sticky exception flags of the floating-point control/status register together with that register's trap-enable bit. Each time the datapath finishes an operation it presents a one-cycle completion pulse, a vector of detailed cause bits and the address of the instruction that produced them. When trapping is enabled, the causes are folded into eight sticky flags. Some causes set more than one flag. The block then asks the exception controller for a floating-point exception whenever any flag in the register is set, including flags that earlier operations left behind.

Software owns the register through a plain write port. A write replaces the enable bit and all eight flags at once, and it takes priority over a completion in the same cycle. The exception request is a one-cycle pulse that comes one cycle after the completion pulse. It carries the address of the faulting instruction, so that the exception controller can record where the fault happened. The arithmetic itself and the exception entry sequence are handled elsewhere.

Top module: `fpx_flag_trap`

## Requirements
- R1: After reset the register reads 0 (trap-enable clear, all flags clear) and no exception is requested.
- R2: Register bit 0 is the trap-enable bit. While it is 0, a completion changes no register bit and requests no exception.
- R3: Cause bits 4 to 12 (4 signalling NaN, 5 quiet NaN, 6 inf minus inf, 7 inf over inf, 8 zero over zero, 9 inf times zero, 10 bad conversion, 11 bad compare, 12 bad square root) each set the invalid flag, register bit 6.
- R4: Cause bit 4 also sets the signalling-NaN flag (bit 7), and cause bit 5 also sets the quiet-NaN flag (bit 8).
- R5: Cause bits 6 and 7 also set the infinity flag, register bit 5.
- R6: Cause bit 0 (overflow) sets bit 1, cause bit 1 (underflow) sets bit 2, cause bit 2 (inexact) sets bit 3 and cause bit 3 (divide by zero) sets bit 4.
- R7: Flags are sticky. A completion only ORs new flags in and never clears one.
- R8: An enabled completion requests an exception if, after its update, any of register bits 8 to 1 is set, whether the flag came from this operation or an earlier one. If none is set, no exception is requested.
- R9: The request is high for exactly the one cycle that follows the completion pulse, and during that cycle the reported address equals the address given with that completion.
- R10: A software write loads all nine register bits from the write data. When a write and a completion occur in the same cycle, the write wins: the completion is dropped and no exception is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fpu_done | input | 1 | One-cycle pulse when an operation completes |
| fpu_cause | input | 13 | Detailed cause bits of the completed operation |
| fpu_pc | input | PC_W | Address of the completed instruction |
| csr_wr | input | 1 | Software write strobe |
| csr_wdata | input | 9 | Write data: bit 0 enable, bits 8:1 flags |
| csr_rdata | output | 9 | Current register contents |
| fpe_req | output | 1 | One-cycle floating-point exception request |
| fpe_pc | output | PC_W | Address of the faulting instruction, valid with fpe_req |

## Verification
The bench builds the block with a 24-bit address width. With that width, the reported address can be checked against distinct per-operation addresses without relying on the default width. The bench walks every cause bit on its own from a cleared register, which checks the folding of several causes into the invalid, NaN and infinity flags. It also drives leftover flags with an empty cause vector, back-to-back completions, and a write that collides with a completion.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int NUM_CAUSE = 13;
    localparam int NUM_FLAG  = 8;
    localparam int CSR_W     = NUM_FLAG + 1;

    // cause vector positions
    localparam int C_OVF  = 0;
    localparam int C_UNF  = 1;
    localparam int C_IX   = 2;
    localparam int C_DZ   = 3;
    localparam int C_SNAN = 4;
    localparam int C_QNAN = 5;
    localparam int C_ISI  = 6;
    localparam int C_IDI  = 7;
    localparam int C_ZDZ  = 8;
    localparam int C_IMZ  = 9;
    localparam int C_CVT  = 10;
    localparam int C_CMP  = 11;
    localparam int C_SQRT = 12;

    // flag vector positions (register bit = index + 1)
    localparam int F_OVF  = 0;
    localparam int F_UNF  = 1;
    localparam int F_IX   = 2;
    localparam int F_DZ   = 3;
    localparam int F_INF  = 4;
    localparam int F_INV  = 5;
    localparam int F_SNAN = 6;
    localparam int F_QNAN = 7;

    typedef struct packed {
        logic [NUM_FLAG-1:0] flags;
        logic                en;
    } fpx_csr_t;

    // which cause bits feed one flag
    function automatic logic [NUM_CAUSE-1:0] flag_mask(input int f);
        logic [NUM_CAUSE-1:0] m;
        m = '0;
        case (f)
            F_OVF:  m[C_OVF] = 1'b1;
            F_UNF:  m[C_UNF] = 1'b1;
            F_IX:   m[C_IX]  = 1'b1;
            F_DZ:   m[C_DZ]  = 1'b1;
            F_INF:  begin m[C_ISI] = 1'b1; m[C_IDI] = 1'b1; end
            F_INV:  begin
                for (int c = C_SNAN; c <= C_SQRT; c++) m[c] = 1'b1;
            end
            F_SNAN: m[C_SNAN] = 1'b1;
            F_QNAN: m[C_QNAN] = 1'b1;
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/fpx_cause_map.sv
module fpx_cause_map
    import fpx_pkg::*;
(
    input  logic [NUM_CAUSE-1:0] cause,
    output logic [NUM_FLAG-1:0]  set_flags
);

    for (genvar f = 0; f < NUM_FLAG; f++) begin : g_flag
        localparam logic [NUM_CAUSE-1:0] MASK = flag_mask(f);
        assign set_flags[f] = |(cause & MASK);
    end

    always_comb begin
        if (cause[C_SNAN]) begin
            p_snan_folds_r4: assert (set_flags[F_INV] && set_flags[F_SNAN]);
        end
        if (cause[C_ISI] || cause[C_IDI]) begin
            p_inf_folds_r5: assert (set_flags[F_INV] && set_flags[F_INF]);
        end
        if (cause[C_SQRT]) begin
            p_sqrt_invalid_r3: assert (set_flags[F_INV]);
        end
    end

endmodule

// File: rtl/fpx_csr_file.sv
module fpx_csr_file
    import fpx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd_valid,
    input  logic [NUM_FLAG-1:0] set_flags,
    input  logic                wr_en,
    input  logic [CSR_W-1:0]    wr_data,
    output logic [CSR_W-1:0]    csr_q,
    output logic                fire
);

    fpx_csr_t state_d, state_q;
    logic     fire_d;

    always_comb begin
        state_d = state_q;
        fire_d  = 1'b0;
        if (wr_en) begin
            state_d = fpx_csr_t'(wr_data);
        end else if (upd_valid && state_q.en) begin
            state_d.flags = state_q.flags | set_flags;
            fire_d        = |state_d.flags;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign csr_q = state_q;
    assign fire  = fire_d;

    p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> csr_q == $past(wr_data));

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> ((csr_q[CSR_W-1:1] & $past(csr_q[CSR_W-1:1]))
                           == $past(csr_q[CSR_W-1:1])));

    p_disabled_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && !$past(csr_q[0])) |-> csr_q == $past(csr_q));

endmodule

// File: rtl/fpx_trap_pulse.sv
module fpx_trap_pulse #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic [PC_W-1:0] src_pc,
    output logic            req,
    output logic [PC_W-1:0] pc
);

    typedef struct packed {
        logic            req;
        logic [PC_W-1:0] pc;
    } trap_t;

    trap_t trap_d, trap_q;

    always_comb begin
        trap_d     = trap_q;
        trap_d.req = fire;
        if (fire) begin
            trap_d.pc = src_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_q <= '0;
        end else begin
            trap_q <= trap_d;
        end
    end

    assign req = trap_q.req;
    assign pc  = trap_q.pc;

endmodule

// File: rtl/fpx_flag_trap.sv
module fpx_flag_trap
    import fpx_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fpu_done,
    input  logic [NUM_CAUSE-1:0] fpu_cause,
    input  logic [PC_W-1:0]      fpu_pc,
    input  logic                 csr_wr,
    input  logic [CSR_W-1:0]     csr_wdata,
    output logic [CSR_W-1:0]     csr_rdata,
    output logic                 fpe_req,
    output logic [PC_W-1:0]      fpe_pc
);

    logic [NUM_FLAG-1:0] set_flags;
    logic                fire;

    fpx_cause_map u_map (
        .cause     (fpu_cause),
        .set_flags (set_flags)
    );

    fpx_csr_file u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (fpu_done),
        .set_flags (set_flags),
        .wr_en     (csr_wr),
        .wr_data   (csr_wdata),
        .csr_q     (csr_rdata),
        .fire      (fire)
    );

    fpx_trap_pulse #(.PC_W(PC_W)) u_trap (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .src_pc (fpu_pc),
        .req    (fpe_req),
        .pc     (fpe_pc)
    );

    p_req_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fpe_req |-> $past(fpu_done) && !$past(csr_wr));

    p_req_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fpe_req |-> fpe_pc == $past(fpu_pc));

    p_req_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fpe_req |-> $past(csr_rdata[0]));

    p_req_has_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fpe_req |-> |csr_rdata[CSR_W-1:1]);

endmodule

// File: tb/fpx_flag_trap_tb_top.sv
`timescale 1ns/1ps
module fpx_flag_trap_tb_top;

    localparam int PC_W = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fpu_done = 1'b0;
    logic [12:0]     fpu_cause = '0;
    logic [PC_W-1:0] fpu_pc = '0;
    logic            csr_wr = 1'b0;
    logic [8:0]      csr_wdata = '0;
    logic [8:0]      csr_rdata;
    logic            fpe_req;
    logic [PC_W-1:0] fpe_pc;

    int tests = 0;
    int fails = 0;

    logic [8:0]      m_csr = '0;
    logic [8:0]      q_csr[$];
    logic            q_trap[$];
    logic [PC_W-1:0] q_pc[$];
    string           q_tag[$];

    always #10 clk = ~clk;

    fpx_flag_trap #(.PC_W(PC_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fpu_done  (fpu_done),
        .fpu_cause (fpu_cause),
        .fpu_pc    (fpu_pc),
        .csr_wr    (csr_wr),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .fpe_req   (fpe_req),
        .fpe_pc    (fpe_pc)
    );

    // flag set from causes, register bit positions per R3..R6
    function automatic logic [8:0] cause_bits(input logic [12:0] c);
        logic [8:0] r;
        r = '0;
        if (c[0]) r[1] = 1'b1;
        if (c[1]) r[2] = 1'b1;
        if (c[2]) r[3] = 1'b1;
        if (c[3]) r[4] = 1'b1;
        if (c[6] || c[7]) r[5] = 1'b1;
        if (|c[12:4]) r[6] = 1'b1;
        if (c[4]) r[7] = 1'b1;
        if (c[5]) r[8] = 1'b1;
        return r;
    endfunction

    task automatic step(input logic v, input logic [12:0] c, input logic [PC_W-1:0] pc,
                        input logic w, input logic [8:0] wd, input string tag);
        logic [8:0] nxt;
        logic       trap;
        @(negedge clk);
        fpu_done  = v;
        fpu_cause = c;
        fpu_pc    = pc;
        csr_wr    = w;
        csr_wdata = wd;
        trap = 1'b0;
        nxt  = m_csr;
        if (w) begin
            nxt = wd;
        end else if (v && m_csr[0]) begin
            nxt  = m_csr | cause_bits(c);
            trap = |nxt[8:1];
        end
        m_csr = nxt;
        q_csr.push_back(nxt);
        q_trap.push_back(trap);
        q_pc.push_back(pc);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, '0, '0, 1'b0, '0, tag);
    endtask

    // monitor: compare each expected item after the edge that produces it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_csr.size() > 0) begin
                logic [8:0]      e_csr;
                logic            e_trap;
                logic [PC_W-1:0] e_pc;
                string           e_tag;
                e_csr  = q_csr.pop_front();
                e_trap = q_trap.pop_front();
                e_pc   = q_pc.pop_front();
                e_tag  = q_tag.pop_front();
                tests++;
                if (csr_rdata !== e_csr || fpe_req !== e_trap ||
                    (e_trap && fpe_pc !== e_pc)) begin
                    fails++;
                    $display("FAIL %s: csr=%h req=%b pc=%h expected csr=%h req=%b pc=%h",
                             e_tag, csr_rdata, fpe_req, fpe_pc, e_csr, e_trap, e_pc);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tests++;
        if (csr_rdata !== 9'h000 || fpe_req !== 1'b0) begin
            fails++;
            $display("FAIL R1: csr=%h req=%b expected csr=000 req=0", csr_rdata, fpe_req);
        end

        // R2: disabled, every cause ignored
        step(1'b1, 13'h1fff, 24'h000100, 1'b0, 9'h000, "R2 disabled all causes");
        idle("R2 no request while disabled");
        step(1'b0, '0, '0, 1'b1, 9'h0a8, "R10 write flags with enable clear");
        step(1'b1, 13'h0001, 24'h000104, 1'b0, 9'h000, "R2 disabled keeps flags");
        idle("R2 still no request");

        // R3..R6: each cause alone from a cleared, enabled register
        for (int c = 0; c < 13; c++) begin
            string t;
            if (c < 4)       t = "R6 single cause";
            else if (c < 6)  t = "R4 NaN cause";
            else if (c < 8)  t = "R5 infinity cause";
            else             t = "R3 invalid cause";
            step(1'b0, '0, '0, 1'b1, 9'h001, "R10 clear and enable");
            step(1'b1, 13'(1 << c), 24'(24'h001000 + c * 4), 1'b0, 9'h000, t);
            idle("R9 single-cycle request");
        end

        // R7 sticky and R8 leftover flags
        step(1'b0, '0, '0, 1'b1, 9'h001, "R10 clear and enable");
        step(1'b1, 13'h0000, 24'h002000, 1'b0, 9'h000, "R8 no flags no request");
        step(1'b1, 13'h0001, 24'h002004, 1'b0, 9'h000, "R7 overflow first");
        step(1'b1, 13'h0002, 24'h002008, 1'b0, 9'h000, "R7 underflow added");
        step(1'b1, 13'h0000, 24'h00200c, 1'b0, 9'h000, "R8 leftover flags request");
        idle("R9 request drops");

        // R9 back-to-back completions carry their own addresses
        step(1'b1, 13'h0008, 24'h003000, 1'b0, 9'h000, "R9 back-to-back first");
        step(1'b1, 13'h0004, 24'h003abc, 1'b0, 9'h000, "R9 back-to-back second");
        idle("R9 request drops after burst");

        // R10 write collides with a completion
        step(1'b1, 13'h0001, 24'h004000, 1'b1, 9'h001, "R10 write wins over completion");
        idle("R10 no request after collision");
        step(1'b0, '0, '0, 1'b1, 9'h1ff, "R10 write all ones");
        step(1'b1, 13'h0000, 24'h004444, 1'b0, 9'h000, "R8 preloaded flags request");
        step(1'b0, '0, '0, 1'b1, 9'h000, "R10 write zero");
        idle("R2 settled");

        while (q_csr.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule